// File: doc/BRIEF.md
# Synchronous Serial Master with Word FIFOs

This block is a master for a four-wire synchronous serial link (SPI-style). Software talks to it through a small word-wide register port. Words written to the data register are queued in an eight-entry transmit FIFO. The block shifts each word out on the serial data output while it captures a word of equal length from the serial data input, and it queues every captured word in an eight-entry receive FIFO. A read of the same data register returns the oldest received word.

The bit clock comes from two cascaded dividers: an even prescale value and a second factor of (1 + rate field). Clock idle level and capture phase can be chosen independently, which gives all four clock modes. Word length runs from 4 to 16 bits. A loopback switch feeds the block's own output back to its receive shifter.

An active-low frame-select output is driven automatically around each word. It stays low across consecutive words as long as more data is queued. A status register reports FIFO occupancy and activity.

Top module: `sync_serial_master`

## Requirements
- R1: After reset, the status register reads 0x03, the frame select is high and the serial clock is low.
- R2: Register offsets are: control A at 0x00, control B at 0x04, data at 0x08, status at 0x0C and prescale at 0x10.
  - Control A holds the rate field in bits 15:8, the phase bit in bit 7, the polarity bit in bit 6, a stored format field in bits 5:4 and the width code in bits 3:0.
  - Control B holds loopback in bit 0, run in bit 1 and a stored role bit in bit 2.
  - Control A, control B and prescale read back what was written.
- R3: Bit 0 of the prescale register always reads 0. A stored prescale below 2 acts as 2. Each half period of the serial clock lasts (prescale / 2) × (1 + rate) system clocks.
- R4: The width code is the word length minus one. Codes 0 to 2 select 4-bit words.
- R5: While the frame select is high, the serial clock rests at the polarity bit.
- R6: With phase 0, input is captured on odd clock edges of a word and output changes on even edges. With phase 1, output changes on odd edges and input is captured on even edges. Edges are counted from 1.
- R7: Words are shifted most significant bit first. Each sent word yields exactly one received word, made of its low width bits. A received word that arrives while the receive FIFO is full is lost.
- R8: Each FIFO holds 8 words. The status register has these bits:
  - bit 0: transmit FIFO empty
  - bit 1: transmit FIFO not full
  - bit 2: receive FIFO not empty
  - bit 3: receive FIFO full
  - bit 4: busy
- R9: The frame select falls one half period before the first clock edge and rises one half period after the last edge. Back-to-back queued words keep it low without a break, so a burst lasts (2 × width + 1) half periods per word.
- R10: With loopback set, the received word equals the sent word and the external serial input has no effect.
- R11: A data read with the receive FIFO empty returns 0. A data write with the transmit FIFO full is discarded.
- R12: While run is set, writes to control A and prescale are ignored. While run is clear, no frame starts.
- R13: Busy is set while a word is being shifted or while the transmit FIFO is not empty, even when run is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register access strobe, one cycle per access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 5 | Byte offset of the register |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, valid during a read access |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| frameN | output | 1 | Active-low frame select |

## Verification
The hardest state to reach from the ports is a receive FIFO that is already full while one more word is shifted. The same run must also leave a ninth transmit write discarded and keep the frame select low through eight back-to-back words. The bench gets there by queueing nine words while run is clear, then setting run with loopback and timing the single low burst. It then sends one extra word before draining the receive side, and finally reads once more past empty. A bench-side serial slave, which counts clock edges per word, checks every clock mode and width for bit order and capture phase.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] OFS_CTRLA = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_CTRLB = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_DATA  = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_PRE   = 5'h10;

  typedef enum logic {ST_IDLE, ST_XFER} xfer_state_t;

  // strobes from bit-timing control to the datapath
  typedef struct packed {
    logic load;    // pop transmit FIFO into the shifter, clear receive shifter
    logic shift;   // present the next output bit
    logic sample;  // capture one input bit
    logic finish;  // word complete, push receive word
  } strobe_t;
endpackage

// File: rtl/ssm_fifo.sv
module ssm_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wData,
  output logic [WIDTH-1:0] rData,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic doPush, doPop;

  assign empty  = (count == '0);
  assign full   = (count == CNT_W'(DEPTH));
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign rData  = store[rdPtr];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) store[wrPtr] <= wData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= bump(wrPtr);
      if (doPop)  rdPtr <= bump(rdPtr);
      if (doPush && !doPop)      count <= count + CNT_W'(1);
      else if (doPop && !doPush) count <= count - CNT_W'(1);
    end
  end
endmodule

// File: rtl/ssm_ctrl.sv
module ssm_ctrl
  import ssm_pkg::*;
#(
  parameter int WW_W = 5
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            enable,
  input  logic            txEmpty,
  input  logic [6:0]      halfPre,
  input  logic [7:0]      scr,
  input  logic [WW_W-1:0] wordW,
  input  logic            pha,
  output strobe_t         stb,
  output logic            sclkLvl,
  output logic            frameN,
  output logic            active
);
  localparam int EC_W = WW_W + 1;

  xfer_state_t state;
  logic [6:0]      preCnt;
  logic [7:0]      scrCnt;
  logic [EC_W-1:0] edgeCnt, nextEdge, lastEdge;
  logic preWrap, scrWrap, halfTick, edgeStep, finishStep, oddEdge;

  assign preWrap    = (preCnt == halfPre - 7'd1);
  assign scrWrap    = (scrCnt == scr);
  assign halfTick   = (state == ST_XFER) && preWrap && scrWrap;
  assign lastEdge   = {wordW, 1'b0};
  assign nextEdge   = edgeCnt + EC_W'(1);
  assign oddEdge    = nextEdge[0];
  assign edgeStep   = halfTick && (edgeCnt != lastEdge);
  assign finishStep = halfTick && (edgeCnt == lastEdge);
  assign active     = (state == ST_XFER);

  always_comb begin
    stb.finish = finishStep;
    stb.sample = edgeStep && (pha ? !oddEdge : oddEdge);
    stb.shift  = edgeStep && (pha ? (oddEdge && nextEdge != EC_W'(1))
                                  : (!oddEdge && nextEdge != lastEdge));
    stb.load   = enable && !txEmpty && ((state == ST_IDLE) || finishStep);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      preCnt  <= '0;
      scrCnt  <= '0;
      edgeCnt <= '0;
      sclkLvl <= 1'b0;
      frameN  <= 1'b1;
    end else if (stb.load) begin
      state   <= ST_XFER;
      frameN  <= 1'b0;
      preCnt  <= '0;
      scrCnt  <= '0;
      edgeCnt <= '0;
      sclkLvl <= 1'b0;
    end else if (finishStep) begin
      state   <= ST_IDLE;
      frameN  <= 1'b1;
      preCnt  <= '0;
      scrCnt  <= '0;
      edgeCnt <= '0;
    end else if (state == ST_XFER) begin
      if (preWrap) begin
        preCnt <= '0;
        scrCnt <= scrWrap ? '0 : scrCnt + 8'd1;
      end else begin
        preCnt <= preCnt + 7'd1;
      end
      if (halfTick) begin
        edgeCnt <= nextEdge;
        sclkLvl <= ~sclkLvl;
      end
    end
  end
endmodule

// File: rtl/ssm_datapath.sv
module ssm_datapath
  import ssm_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int DEPTH   = 8,
  parameter int WW_W    = $clog2(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  strobe_t           stb,
  input  logic              active,
  input  logic              miso,
  output logic              mosi,
  output logic              cfgRun,
  output logic              cfgPol,
  output logic              cfgPha,
  output logic [7:0]        cfgScr,
  output logic [6:0]        halfPre,
  output logic [WW_W-1:0]   wordW,
  output logic              txEmpty
);
  localparam int WC_W = $clog2(DATA_W);

  logic [DATA_W-1:0] ctrlA;
  logic [2:0]        ctrlB;
  logic [7:0]        preReg, preEff;
  logic [WC_W-1:0]   wcode;
  logic [DATA_W-1:0] txShift, rxShift, txHead, rxHead, wMask;
  logic txFull, rxEmpty, rxFull, inBit;
  logic wrA, wrB, wrPre, wrData, rdData;

  assign wrA    = busSel && busWrite && (busAddr == OFS_CTRLA);
  assign wrB    = busSel && busWrite && (busAddr == OFS_CTRLB);
  assign wrPre  = busSel && busWrite && (busAddr == OFS_PRE);
  assign wrData = busSel && busWrite && (busAddr == OFS_DATA);
  assign rdData = busSel && !busWrite && (busAddr == OFS_DATA);

  assign cfgScr  = ctrlA[15:8];
  assign cfgPha  = ctrlA[7];
  assign cfgPol  = ctrlA[6];
  assign wcode   = ctrlA[WC_W-1:0];
  assign cfgRun  = ctrlB[1];
  assign wordW   = (wcode < WC_W'(3)) ? WW_W'(4) : WW_W'(wcode) + WW_W'(1);
  assign preEff  = (preReg < 8'd2) ? 8'd2 : preReg;
  assign halfPre = preEff[7:1];

  always_comb begin
    for (int i = 0; i < DATA_W; i++) wMask[i] = (i < int'(wordW));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlA  <= '0;
      ctrlB  <= '0;
      preReg <= '0;
    end else begin
      if (wrA && !cfgRun)   ctrlA  <= busWdata;
      if (wrB)              ctrlB  <= busWdata[2:0];
      if (wrPre && !cfgRun) preReg <= {busWdata[7:1], 1'b0};
    end
  end

  ssm_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rstN(rstN), .push(wrData), .pop(stb.load),
    .wData(busWdata), .rData(txHead), .empty(txEmpty), .full(txFull)
  );

  ssm_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rstN(rstN), .push(stb.finish), .pop(rdData),
    .wData(rxShift & wMask), .rData(rxHead), .empty(rxEmpty), .full(rxFull)
  );

  assign mosi  = txShift[wordW - WW_W'(1)];
  assign inBit = ctrlB[0] ? mosi : miso;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
    end else begin
      if (stb.load)       txShift <= txHead;
      else if (stb.shift) txShift <= {txShift[DATA_W-2:0], 1'b0};
      if (stb.load)        rxShift <= '0;
      else if (stb.sample) rxShift <= {rxShift[DATA_W-2:0], inBit};
    end
  end

  always_comb begin
    case (busAddr)
      OFS_CTRLA: busRdata = ctrlA;
      OFS_CTRLB: busRdata = {{(DATA_W-3){1'b0}}, ctrlB};
      OFS_DATA:  busRdata = rxEmpty ? '0 : rxHead;
      OFS_STAT:  busRdata = {{(DATA_W-5){1'b0}}, (active || !txEmpty),
                             rxFull, !rxEmpty, !txFull, txEmpty};
      OFS_PRE:   busRdata = {{(DATA_W-8){1'b0}}, preReg};
      default:   busRdata = '0;
    endcase
  end
endmodule

// File: rtl/sync_serial_master.sv
module sync_serial_master
  import ssm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              frameN
);
  localparam int WW_W = $clog2(DATA_W) + 1;

  strobe_t         stb;
  logic            active, txEmpty, cfgRun, cfgPol, cfgPha, sclkLvl;
  logic [7:0]      cfgScr;
  logic [6:0]      halfPre;
  logic [WW_W-1:0] wordW;

  ssm_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH), .WW_W(WW_W)) u_dp (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .stb(stb), .active(active), .miso(miso), .mosi(mosi),
    .cfgRun(cfgRun), .cfgPol(cfgPol), .cfgPha(cfgPha), .cfgScr(cfgScr),
    .halfPre(halfPre), .wordW(wordW), .txEmpty(txEmpty)
  );

  ssm_ctrl #(.WW_W(WW_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(cfgRun), .txEmpty(txEmpty),
    .halfPre(halfPre), .scr(cfgScr), .wordW(wordW), .pha(cfgPha),
    .stb(stb), .sclkLvl(sclkLvl), .frameN(frameN), .active(active)
  );

  assign sclk = sclkLvl ^ cfgPol;
endmodule

// File: rtl/ssm_checker.sv
module ssm_checker (
  input logic clk,
  input logic rstN,
  input logic frameN,
  input logic sclk,
  input logic cfgPol,
  input logic cfgRun,
  input logic txEmpty
);
  p_sclk_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    frameN |-> (sclk == cfgPol));

  p_frame_start_r12: assert property (@(posedge clk) disable iff (!rstN)
    $fell(frameN) |-> $past(cfgRun && !txEmpty));

  p_frame_release_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameN) |-> $past(txEmpty || !cfgRun));

  p_hold_off_r12: assert property (@(posedge clk) disable iff (!rstN)
    (frameN && !cfgRun) |=> frameN);
endmodule

bind sync_serial_master ssm_checker u_chk (
  .clk(clk), .rstN(rstN), .frameN(frameN), .sclk(sclk),
  .cfgPol(cfgPol), .cfgRun(cfgRun), .txEmpty(txEmpty)
);

// File: tb/sync_serial_master_bench.sv
module sync_serial_master_bench;
  import ssm_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWrite = 1'b0;
  logic [4:0] busAddr = '0;
  logic [15:0] busWdata = '0, busRdata;
  logic sclk, mosi, frameN;
  logic miso;

  always #5 clk = ~clk;

  sync_serial_master u_sync_serial_master (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .frameN(frameN)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // serial slave model: counts edges per word
  int sPha = 0, sW = 8, sEdge = 0, capCnt = 0;
  logic [15:0] sWordNext = '0, sOut = '0, sIn = '0;
  logic sPrev = 1'b0;
  logic [15:0] capLog [64];

  always @(sclk, frameN, sWordNext, sW) begin
    if (frameN) begin
      sEdge = 0; sOut = sWordNext; sIn = '0; miso = sOut[sW-1];
    end else if (sclk !== sPrev) begin
      sEdge++;
      if ((sPha == 0) ? (sEdge % 2 == 1) : (sEdge % 2 == 0)) sIn = {sIn[14:0], mosi};
      if ((sPha == 0) ? (sEdge % 2 == 0 && sEdge < 2*sW) : (sEdge % 2 == 1 && sEdge > 1)) begin
        sOut = sOut << 1; miso = sOut[sW-1];
      end
      if (sEdge == 2*sW) begin
        if (capCnt < 64) capLog[capCnt] = sIn;
        capCnt++;
        sEdge = 0; sOut = sWordNext; sIn = '0; miso = sOut[sW-1];
      end
    end
    sPrev = sclk;
  end

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); busSel = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(negedge clk); busSel = 0; busWrite = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk); busSel = 1; busWrite = 0; busAddr = a;
    #1 d = busRdata;
    @(negedge clk); busSel = 0;
  endtask

  task automatic waitIdle();
    logic [15:0] s;
    int n = 0;
    do begin rd(OFS_STAT, s); n++; end while (s[4] && n < 5000);
  endtask

  task automatic measure(input logic pol, output int lead, output int low);
    int n = 0;
    int guard = 0;
    lead = -1;
    while (frameN && guard < 1000) begin @(negedge clk); guard++; end
    while (!frameN && n < 50000) begin
      if (lead < 0 && sclk != pol) lead = n;
      @(negedge clk); n++;
    end
    low = n;
  endtask

  // {pol, pha, widthCode, loop, txWord, slaveWord}
  localparam int NV = 8;
  localparam logic [38:0] VEC [NV] = '{
    {1'b0, 1'b0, 4'd7,  1'b0, 16'h00A5, 16'h003C},
    {1'b0, 1'b1, 4'd7,  1'b0, 16'h0081, 16'h00E7},
    {1'b1, 1'b0, 4'd7,  1'b0, 16'h0055, 16'h00C3},
    {1'b1, 1'b1, 4'd7,  1'b0, 16'h00F0, 16'h000F},
    {1'b0, 1'b0, 4'd15, 1'b0, 16'hBEEF, 16'h1234},
    {1'b1, 1'b1, 4'd3,  1'b0, 16'h007B, 16'h0006},
    {1'b0, 1'b0, 4'd7,  1'b1, 16'h0096, 16'h00FF},
    {1'b0, 1'b1, 4'd1,  1'b0, 16'h00AD, 16'h0009}
  };

  initial begin
    logic [15:0] r;
    int lead, low;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    rd(OFS_STAT, r); check(r == 16'h0003, "R1 status", r, 3);
    check(frameN == 1'b1, "R1 frame", frameN, 1);
    check(sclk == 1'b0, "R1 sclk", sclk, 0);
    // R11 empty read
    rd(OFS_DATA, r); check(r == 0, "R11 empty read", r, 0);

    // R2 register readback
    wr(OFS_CTRLA, 16'h3A47); rd(OFS_CTRLA, r); check(r == 16'h3A47, "R2 ctrlA", r, 16'h3A47);
    wr(OFS_CTRLB, 16'h0004); rd(OFS_CTRLB, r); check(r == 16'h0004, "R2 ctrlB", r, 4);
    wr(OFS_CTRLB, 16'h0000);

    // R3 prescale forcing
    wr(OFS_PRE, 16'h0005); rd(OFS_PRE, r); check(r == 16'h0004, "R3 prescale even", r, 4);
    wr(OFS_PRE, 16'h0001); rd(OFS_PRE, r); check(r == 16'h0000, "R3 prescale low", r, 0);

    // vector table: modes, widths, loopback
    for (int i = 0; i < NV; i++) begin
      logic [38:0] v;
      int effW, mask, expRx, expCap, cap0;
      v = VEC[i];
      effW = (v[36:33] < 3) ? 4 : int'(v[36:33]) + 1;
      mask = (1 << effW) - 1;
      expRx = v[32] ? (int'(v[31:16]) & mask) : (int'(v[15:0]) & mask);
      expCap = int'(v[31:16]) & mask;
      wr(OFS_CTRLB, 16'h0000);
      wr(OFS_CTRLA, {8'd0, v[37], v[38], 2'b00, v[36:33]});
      wr(OFS_PRE, 16'h0002);
      sPha = int'(v[37]); sW = effW; sWordNext = v[15:0];
      cap0 = capCnt;
      check(sclk == v[38], "R5 idle polarity", sclk, v[38]);
      wr(OFS_DATA, v[31:16]);
      wr(OFS_CTRLB, v[32] ? 16'h0003 : 16'h0002);
      waitIdle();
      rd(OFS_DATA, r);
      check(int'(r) == expRx, v[32] ? "R10 loopback rx" : "R6 R4 mode rx", r, expRx);
      check(capCnt == cap0 + 1, "R7 one word per frame", capCnt - cap0, 1);
      check(int'(capLog[cap0]) == expCap, "R7 msb first out", capLog[cap0], expCap);
      check(sclk == v[38], "R5 idle after frame", sclk, v[38]);
    end

    // R3 R9 timing with half period 1
    wr(OFS_CTRLB, 16'h0000);
    wr(OFS_PRE, 16'h0000);
    wr(OFS_CTRLA, 16'h0007);
    sPha = 0; sW = 8; sWordNext = 16'h0000;
    wr(OFS_DATA, 16'h005A);
    wr(OFS_CTRLB, 16'h0003);
    measure(1'b0, lead, low);
    check(lead == 1, "R3 R9 lead half period 1", lead, 1);
    check(low == 17, "R9 frame length 17", low, 17);
    waitIdle(); rd(OFS_DATA, r); check(r == 16'h005A, "R10 loopback", r, 16'h5A);

    // R3 R9 timing with half period (6/2)*(1+2) = 9
    wr(OFS_CTRLB, 16'h0000);
    wr(OFS_PRE, 16'h0006);
    wr(OFS_CTRLA, 16'h0207);
    wr(OFS_DATA, 16'h00C3);
    wr(OFS_CTRLB, 16'h0003);
    measure(1'b0, lead, low);
    check(lead == 9, "R3 lead half period 9", lead, 9);
    check(low == 153, "R3 R9 frame length 153", low, 153);
    waitIdle(); rd(OFS_DATA, r); check(r == 16'h00C3, "R10 loopback", r, 16'hC3);

    // R12 config locked while run set
    wr(OFS_CTRLA, 16'h0003); rd(OFS_CTRLA, r); check(r == 16'h0207, "R12 ctrlA locked", r, 16'h207);
    wr(OFS_PRE, 16'h000A); rd(OFS_PRE, r); check(r == 16'h0006, "R12 prescale locked", r, 6);

    // fill while stopped, then burst
    wr(OFS_CTRLB, 16'h0001);
    wr(OFS_PRE, 16'h0000);
    wr(OFS_CTRLA, 16'h0007);
    for (int k = 1; k <= 9; k++) wr(OFS_DATA, 16'(k * 16'h11));
    rd(OFS_STAT, r); check(r == 16'h0010, "R13 R8 busy while stopped, tx full", r, 16'h10);
    repeat (20) @(negedge clk);
    check(frameN == 1'b1, "R12 no frame while stopped", frameN, 1);
    wr(OFS_CTRLB, 16'h0003);
    measure(1'b0, lead, low);
    check(low == 136, "R9 back-to-back burst", low, 136);
    waitIdle();
    rd(OFS_STAT, r); check(r == 16'h000F, "R8 rx full status", r, 16'hF);
    wr(OFS_DATA, 16'h00EE);
    waitIdle();
    for (int k = 1; k <= 8; k++) begin
      rd(OFS_DATA, r);
      check(int'(r) == k * 16'h11, "R7 R11 rx order after drop", r, k * 16'h11);
    end
    rd(OFS_DATA, r); check(r == 0, "R11 read past empty", r, 0);
    rd(OFS_STAT, r); check(r == 16'h0003, "R8 drained status", r, 3);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule